// File: doc/BRIEF.md
# Segment Translation Unit with Descriptor Cache

This block turns an offset inside a segment into a 32-bit linear address. It keeps four segment registers: code, data, stack and extra. Each register holds a 16-bit selector. When a selector is written, the descriptor it points at is copied from an on-chip descriptor table into a shadow entry for that register. The shadow entry holds the decoded base, the effective limit and the privilege level. Every later access uses the shadow entry and does not read the table again.

For each access the unit picks one segment register. The default comes from the access kind, and data and stack accesses may name a different register instead. The unit adds the base to the offset and checks the offset against the limit. For data and stack accesses it also compares the current privilege level with the segment's level. The current privilege level is the level held in the code register's shadow entry. A result comes out one cycle after the access is presented. With base 0 and the largest page-granular limit the mapping is the identity, and only the privilege check remains.

The descriptor table is filled through a plain write port. A selector whose index falls past the end of the table loads an all-zero null descriptor.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset all four shadow entries are flat (base 0, limit 0xFFFFFFFF, level 0), `out_valid` is low and `cur_priv` is 0.
- R2: With no override, access kind 0 (fetch) uses the code register, kind 2 (stack) uses the stack register, and kinds 1 and 3 (data) use the data register. `out_seg` reports the register used: code 0, data 1, stack 2, extra 3.
- R3: When `acc_ovr_en` is high, a data or stack access uses the register given by `acc_ovr_seg`. A fetch ignores the override and always uses the code register.
- R4: `out_linear` is the base plus the offset, taken modulo 2^32.
- R5: The effective limit is the 20-bit limit field zero-extended when the granularity bit is 0. When the granularity bit is 1 it is the field shifted left by 12 with the low 12 bits set to one. An offset greater than the effective limit raises `out_limit_fault` and drives `out_lin_ok` low.
- R6: A data or stack access whose current privilege level is numerically greater than the segment's level raises `out_priv_fault` and drives `out_lin_ok` low. A fetch never raises a privilege fault.
- R7: `cur_priv` equals the level in the code register's shadow entry. It changes only when the code register is written.
- R8: The layout of a 64-bit descriptor is: base in bits [31:0], limit in bits [51:32], level in bits [61:60] and granularity in bit 62. A table entry is written at the edge where `tbl_wr_en` is high.
- R9: A write to a segment register indexes the table with selector bits [15:3] and ignores bits [2:0]. An index at or beyond the table depth loads the null descriptor. The new shadow entry applies to accesses presented from the next cycle on.
- R10: Every access gives exactly one result in the cycle after it is presented. `out_valid` is low in cycles that follow no access.
- R11: A descriptor with base 0, limit 0xFFFFF and granularity 1 maps every offset to the same linear address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Descriptor table write strobe |
| tbl_wr_idx | input | IDX_W | Table entry to write |
| tbl_wr_data | input | 64 | Descriptor to store |
| sreg_wr_en | input | 1 | Segment register write strobe |
| sreg_wr_seg | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| sreg_wr_sel | input | 16 | Selector value |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | 0 fetch, 1 data, 2 stack, 3 data |
| acc_ovr_en | input | 1 | Use explicit register for data and stack |
| acc_ovr_seg | input | 2 | Register named by the override |
| acc_offset | input | 32 | Offset within the segment |
| out_valid | output | 1 | Result present |
| out_seg | output | 2 | Register that was used |
| out_linear | output | 32 | Linear address |
| out_lin_ok | output | 1 | Linear address usable (no fault) |
| out_limit_fault | output | 1 | Offset beyond limit |
| out_priv_fault | output | 1 | Privilege check failed |
| cur_priv | output | 2 | Current privilege level |

## Verification
The hardest case to reach is a privilege fault. After reset every entry is level 0, so the current level is 0 and no access can fail the check. To get there, the stimulus first writes a level-3 descriptor into the table and loads it into the code register, which moves `cur_priv` to 3. It then points the data register at a level-0 descriptor. The stimulus also loads the code register back to level 0 to show that the current level follows only code register writes. A selector past the table depth and selectors with nonzero low bits are driven on purpose, to cover the null-descriptor and ignored-bit rules.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SEG_N  = 4;
  localparam int SEG_W  = 2;
  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int LIN_W  = 32;
  localparam int SIDX_W = SEL_W - 3;

  typedef enum logic [SEG_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_DATA  = 2'd1,
    ACC_STACK = 2'd2,
    ACC_DATA2 = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [LIN_W-1:0] base;
    logic [LIN_W-1:0] limit;
    logic [1:0]       dpl;
  } seg_cache_t;

  // base 0, limit field all ones, page granular, level 0
  localparam logic [DESC_W-1:0] FLAT_DESC = 64'h400F_FFFF_0000_0000;

  function automatic logic [LIN_W-1:0] eff_limit(input logic [19:0] field,
                                                 input logic gran);
    if (gran) eff_limit = {field, 12'hFFF};
    else      eff_limit = {12'h000, field};
  endfunction

  function automatic seg_cache_t desc_decode(input logic [DESC_W-1:0] d);
    seg_cache_t c;
    c.base  = d[31:0];
    c.limit = eff_limit(d[51:32], d[62]);
    c.dpl   = d[61:60];
    return c;
  endfunction

  function automatic logic [SIDX_W-1:0] sel_index(input logic [SEL_W-1:0] s);
    return s[SEL_W-1:3];
  endfunction

  function automatic logic [SEG_W-1:0] pick_seg(input logic [1:0] kind,
                                                input logic ovr_en,
                                                input logic [SEG_W-1:0] ovr);
    if (kind == ACC_FETCH)      pick_seg = SEG_CODE;
    else if (ovr_en)            pick_seg = ovr;
    else if (kind == ACC_STACK) pick_seg = SEG_STACK;
    else                        pick_seg = SEG_DATA;
  endfunction

  function automatic logic [LIN_W-1:0] lin_add(input logic [LIN_W-1:0] base,
                                               input logic [LIN_W-1:0] off);
    return base + off;
  endfunction

  function automatic logic over_limit(input logic [LIN_W-1:0] off,
                                      input logic [LIN_W-1:0] lim);
    return off > lim;
  endfunction

  function automatic logic priv_denied(input logic [1:0] kind,
                                       input logic [1:0] cpl,
                                       input logic [1:0] dpl);
    return (kind != ACC_FETCH) && (cpl > dpl);
  endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DESC_W-1:0] wr_data,
  input  logic [SIDX_W-1:0] rd_idx,
  output logic [DESC_W-1:0] rd_desc
);

  logic [DESC_W-1:0] mem_q [DEPTH];
  logic              rd_in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_in_range = (int'(rd_idx) < DEPTH);

  always_comb begin
    if (rd_in_range) rd_desc = mem_q[rd_idx[IDX_W-1:0]];
    else             rd_desc = '0;
  end

endmodule

// File: rtl/seg_shadow_bank.sv
module seg_shadow_bank
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [DESC_W-1:0] ld_desc,
  output seg_cache_t        shadow [SEG_N],
  output logic [1:0]        cpl
);

  seg_cache_t sh_q [SEG_N];
  seg_cache_t ld_dec;

  assign ld_dec = desc_decode(ld_desc);

  for (genvar g = 0; g < SEG_N; g++) begin : g_sh
    always_ff @(posedge clk) begin
      if (!rst_n)
        sh_q[g] <= desc_decode(FLAT_DESC);
      else if (ld_en && (ld_seg == SEG_W'(g)))
        sh_q[g] <= ld_dec;
    end
    assign shadow[g] = sh_q[g];
  end

  assign cpl = sh_q[SEG_CODE].dpl;

endmodule

// File: rtl/seg_check_pipe.sv
module seg_check_pipe
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic             acc_ovr_en,
  input  logic [SEG_W-1:0] acc_ovr_seg,
  input  logic [LIN_W-1:0] acc_offset,
  input  seg_cache_t       shadow [SEG_N],
  input  logic [1:0]       cpl,
  output logic [SEG_W-1:0] sel_seg,
  output logic [LIN_W-1:0] sel_base,
  output logic [LIN_W-1:0] sel_limit,
  output logic [1:0]       sel_dpl,
  output logic             lim_hit,
  output logic             priv_hit,
  output logic             out_valid,
  output logic [SEG_W-1:0] out_seg,
  output logic [LIN_W-1:0] out_linear,
  output logic             out_lin_ok,
  output logic             out_limit_fault,
  output logic             out_priv_fault
);

  seg_cache_t       sel_c;
  logic [LIN_W-1:0] lin_sum;

  assign sel_seg   = pick_seg(acc_kind, acc_ovr_en, acc_ovr_seg);
  assign sel_c     = shadow[sel_seg];
  assign sel_base  = sel_c.base;
  assign sel_limit = sel_c.limit;
  assign sel_dpl   = sel_c.dpl;
  assign lin_sum   = lin_add(sel_base, acc_offset);
  assign lim_hit   = over_limit(acc_offset, sel_limit);
  assign priv_hit  = priv_denied(acc_kind, cpl, sel_dpl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_seg         <= SEG_CODE;
      out_linear      <= '0;
      out_lin_ok      <= 1'b0;
      out_limit_fault <= 1'b0;
      out_priv_fault  <= 1'b0;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) begin
        out_seg         <= sel_seg;
        out_linear      <= lin_sum;
        out_lin_ok      <= !(lim_hit || priv_hit);
        out_limit_fault <= lim_hit;
        out_priv_fault  <= priv_hit;
      end else begin
        out_lin_ok      <= 1'b0;
        out_limit_fault <= 1'b0;
        out_priv_fault  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int TBL_DEPTH = 64,
  localparam int IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic [63:0]       tbl_wr_data,
  input  logic              sreg_wr_en,
  input  logic [1:0]        sreg_wr_seg,
  input  logic [15:0]       sreg_wr_sel,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic              acc_ovr_en,
  input  logic [1:0]        acc_ovr_seg,
  input  logic [31:0]       acc_offset,
  output logic              out_valid,
  output logic [1:0]        out_seg,
  output logic [31:0]       out_linear,
  output logic              out_lin_ok,
  output logic              out_limit_fault,
  output logic              out_priv_fault,
  output logic [1:0]        cur_priv
);

  logic [DESC_W-1:0] ld_desc_w;
  seg_cache_t        shadow_w [SEG_N];
  logic [1:0]        cpl_w;
  logic [SEG_W-1:0]  sel_seg_w;
  logic [LIN_W-1:0]  sel_base_w;
  logic [LIN_W-1:0]  sel_limit_w;
  logic [1:0]        sel_dpl_w;
  logic              lim_hit_w;
  logic              priv_hit_w;

  seg_desc_table #(.DEPTH(TBL_DEPTH)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_en),
    .wr_idx  (tbl_wr_idx),
    .wr_data (tbl_wr_data),
    .rd_idx  (sel_index(sreg_wr_sel)),
    .rd_desc (ld_desc_w)
  );

  seg_shadow_bank u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (sreg_wr_en),
    .ld_seg  (sreg_wr_seg),
    .ld_desc (ld_desc_w),
    .shadow  (shadow_w),
    .cpl     (cpl_w)
  );

  seg_check_pipe u_pipe (
    .clk             (clk),
    .rst_n           (rst_n),
    .acc_valid       (acc_valid),
    .acc_kind        (acc_kind),
    .acc_ovr_en      (acc_ovr_en),
    .acc_ovr_seg     (acc_ovr_seg),
    .acc_offset      (acc_offset),
    .shadow          (shadow_w),
    .cpl             (cpl_w),
    .sel_seg         (sel_seg_w),
    .sel_base        (sel_base_w),
    .sel_limit       (sel_limit_w),
    .sel_dpl         (sel_dpl_w),
    .lim_hit         (lim_hit_w),
    .priv_hit        (priv_hit_w),
    .out_valid       (out_valid),
    .out_seg         (out_seg),
    .out_linear      (out_linear),
    .out_lin_ok      (out_lin_ok),
    .out_limit_fault (out_limit_fault),
    .out_priv_fault  (out_priv_fault)
  );

  assign cur_priv = cpl_w;

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker
  import seg_xlate_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [1:0]  acc_kind,
  input logic [31:0] acc_offset,
  input logic        sreg_wr_en,
  input logic [1:0]  sreg_wr_seg,
  input logic [63:0] ld_desc,
  input logic [31:0] sel_base,
  input logic [31:0] sel_limit,
  input logic [1:0]  sel_dpl,
  input logic [1:0]  cpl,
  input logic        out_valid,
  input logic [1:0]  out_seg,
  input logic [31:0] out_linear,
  input logic        out_lin_ok,
  input logic        out_limit_fault,
  input logic        out_priv_fault
);

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> out_valid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !out_valid); // R10
  AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == ACC_FETCH) |=> (out_seg == SEG_CODE)); // R3
  AST_LIN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (out_linear == $past(sel_base + acc_offset))); // R4
  AST_LIMIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_offset > sel_limit) |=> (out_limit_fault && !out_lin_ok)); // R5
  AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind != ACC_FETCH && cpl > sel_dpl) |=> (out_priv_fault && !out_lin_ok)); // R6
  AST_FETCH_NO_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == ACC_FETCH) |=> !out_priv_fault); // R6
  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sreg_wr_en && sreg_wr_seg == SEG_CODE) |=> $stable(cpl)); // R7
  AST_CPL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sreg_wr_en && sreg_wr_seg == SEG_CODE) |=> (cpl == $past(ld_desc[61:60]))); // R7

endmodule

bind seg_xlate_unit seg_xlate_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .acc_valid       (acc_valid),
  .acc_kind        (acc_kind),
  .acc_offset      (acc_offset),
  .sreg_wr_en      (sreg_wr_en),
  .sreg_wr_seg     (sreg_wr_seg),
  .ld_desc         (ld_desc_w),
  .sel_base        (sel_base_w),
  .sel_limit       (sel_limit_w),
  .sel_dpl         (sel_dpl_w),
  .cpl             (cpl_w),
  .out_valid       (out_valid),
  .out_seg         (out_seg),
  .out_linear      (out_linear),
  .out_lin_ok      (out_lin_ok),
  .out_limit_fault (out_limit_fault),
  .out_priv_fault  (out_priv_fault)
);

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr_en = 1'b0;
  logic [5:0]  tbl_wr_idx = '0;
  logic [63:0] tbl_wr_data = '0;
  logic        sreg_wr_en = 1'b0;
  logic [1:0]  sreg_wr_seg = '0;
  logic [15:0] sreg_wr_sel = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic        acc_ovr_en = 1'b0;
  logic [1:0]  acc_ovr_seg = '0;
  logic [31:0] acc_offset = '0;
  logic        out_valid;
  logic [1:0]  out_seg;
  logic [31:0] out_linear;
  logic        out_lin_ok;
  logic        out_limit_fault;
  logic        out_priv_fault;
  logic [1:0]  cur_priv;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] tbl_m [DEPTH];
  logic [63:0] sh_m  [4];

  always #4 clk = ~clk;

  seg_xlate_unit #(.TBL_DEPTH(DEPTH)) uut (.*);

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                     input logic g, input logic [1:0] lvl);
    return {1'b0, g, lvl, 8'h00, lim, base};
  endfunction

  function automatic logic [31:0] lim_of(input logic [63:0] d);
    return d[62] ? {d[51:32], 12'hFFF} : {12'h000, d[51:32]};
  endfunction

  task automatic check(input string req, input logic ok, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tbl_write(input int idx, input logic [63:0] d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = 6'(idx); tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    tbl_m[idx] = d;
  endtask

  task automatic sreg_write(input logic [1:0] seg, input logic [15:0] sel);
    int idx;
    @(negedge clk);
    sreg_wr_en = 1'b1; sreg_wr_seg = seg; sreg_wr_sel = sel;
    @(negedge clk);
    sreg_wr_en = 1'b0;
    idx = int'(sel >> 3);
    sh_m[seg] = (idx < DEPTH) ? tbl_m[idx] : 64'h0;
  endtask

  // drives one access and compares every output field with the model
  task automatic access(input string req, input logic [1:0] kind, input logic oen,
                        input logic [1:0] oseg, input logic [31:0] off);
    logic [1:0]  eseg;
    logic [31:0] elin;
    logic        elf, epf, eok;
    logic [1:0]  ecpl;
    logic [38:0] act, exp;
    case (kind)
      2'd0:    eseg = 2'd0;
      2'd2:    eseg = oen ? oseg : 2'd2;
      default: eseg = oen ? oseg : 2'd1;
    endcase
    ecpl = sh_m[0][61:60];
    elin = sh_m[eseg][31:0] + off;
    elf  = off > lim_of(sh_m[eseg]);
    epf  = (kind != 2'd0) && (ecpl > sh_m[eseg][61:60]);
    eok  = !elf && !epf;
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = kind; acc_ovr_en = oen; acc_ovr_seg = oseg; acc_offset = off;
    @(negedge clk);
    acc_valid = 1'b0; acc_ovr_en = 1'b0;
    act = {out_valid, out_seg, out_linear, out_lin_ok, out_limit_fault, out_priv_fault};
    exp = {1'b1, eseg, elin, eok, elf, epf};
    check(req, act == exp, 64'(act), 64'(exp));
  endtask

  task automatic t_reset;
    check("R1 out_valid low", out_valid == 1'b0, 64'(out_valid), 64'h0);
    check("R1 cur_priv zero", cur_priv == 2'd0, 64'(cur_priv), 64'h0);
    access("R1 R11 flat fetch", 2'd0, 1'b0, 2'd0, 32'h0000_1234);
    access("R11 flat data top", 2'd1, 1'b0, 2'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 idle no result", out_valid == 1'b0, 64'(out_valid), 64'h0);
  endtask

  task automatic t_select;
    tbl_write(1, mk(32'h1000_0000, 20'hFFFFF, 1'b1, 2'd0));
    tbl_write(2, mk(32'h2000_0000, 20'hFFFFF, 1'b1, 2'd0));
    tbl_write(3, mk(32'h3000_0000, 20'hFFFFF, 1'b1, 2'd0));
    tbl_write(4, mk(32'h4000_0000, 20'hFFFFF, 1'b1, 2'd0));
    sreg_write(2'd0, 16'(1 << 3));
    sreg_write(2'd1, 16'(2 << 3));
    sreg_write(2'd2, 16'(3 << 3));
    sreg_write(2'd3, 16'(4 << 3));
    access("R2 R8 fetch uses code", 2'd0, 1'b0, 2'd0, 32'h10);
    access("R2 data uses data", 2'd1, 1'b0, 2'd0, 32'h20);
    access("R2 stack uses stack", 2'd2, 1'b0, 2'd0, 32'h30);
    access("R2 kind3 uses data", 2'd3, 1'b0, 2'd0, 32'h40);
  endtask

  task automatic t_override;
    access("R3 data override extra", 2'd1, 1'b1, 2'd3, 32'h50);
    access("R3 stack override code", 2'd2, 1'b1, 2'd0, 32'h60);
    access("R3 fetch ignores override", 2'd0, 1'b1, 2'd3, 32'h70);
  endtask

  task automatic t_wrap;
    tbl_write(5, mk(32'hFFFF_F000, 20'hFFFFF, 1'b1, 2'd0));
    sreg_write(2'd3, 16'(5 << 3));
    access("R4 sum wraps", 2'd1, 1'b1, 2'd3, 32'h0000_2000);
    check("R4 wrapped value", out_linear == 32'h0000_1000, 64'(out_linear), 64'h1000);
  endtask

  task automatic t_limit;
    tbl_write(6, mk(32'h0000_5000, 20'h00100, 1'b0, 2'd0));
    tbl_write(7, mk(32'h0000_8000, 20'h00001, 1'b1, 2'd0));
    sreg_write(2'd1, 16'(6 << 3));
    access("R5 byte limit edge ok", 2'd1, 1'b0, 2'd0, 32'h100);
    access("R5 byte limit exceeded", 2'd1, 1'b0, 2'd0, 32'h101);
    check("R5 limit fault seen", out_limit_fault == 1'b1, 64'(out_limit_fault), 64'h1);
    sreg_write(2'd1, 16'(7 << 3));
    access("R5 page limit edge ok", 2'd1, 1'b0, 2'd0, 32'h1FFF);
    access("R5 page limit exceeded", 2'd1, 1'b0, 2'd0, 32'h2000);
  endtask

  task automatic t_priv;
    tbl_write(8, mk(32'h0, 20'hFFFFF, 1'b1, 2'd3));
    sreg_write(2'd0, 16'(8 << 3));
    check("R7 cpl follows code load", cur_priv == 2'd3, 64'(cur_priv), 64'h3);
    sreg_write(2'd1, 16'(1 << 3));
    access("R6 data denied", 2'd1, 1'b0, 2'd0, 32'h4);
    check("R6 privilege fault seen", out_priv_fault == 1'b1, 64'(out_priv_fault), 64'h1);
    sreg_write(2'd2, 16'(8 << 3));
    access("R6 stack same level ok", 2'd2, 1'b0, 2'd0, 32'h8);
    access("R6 fetch no privilege check", 2'd0, 1'b0, 2'd0, 32'hC);
    check("R7 cpl held on data load", cur_priv == 2'd3, 64'(cur_priv), 64'h3);
    sreg_write(2'd0, 16'(1 << 3));
    check("R7 cpl back to zero", cur_priv == 2'd0, 64'(cur_priv), 64'h0);
    access("R6 data allowed at ring 0", 2'd1, 1'b0, 2'd0, 32'h4);
  endtask

  task automatic t_null;
    sreg_write(2'd3, 16'(100 << 3));
    access("R9 null descriptor offset 0", 2'd1, 1'b1, 2'd3, 32'h0);
    access("R9 null descriptor offset 1", 2'd1, 1'b1, 2'd3, 32'h1);
    sreg_write(2'd1, 16'((2 << 3) | 7));
    access("R9 low selector bits ignored", 2'd1, 1'b0, 2'd0, 32'h44);
    check("R9 base from entry 2", out_linear == 32'h2000_0044, 64'(out_linear), 64'h2000_0044);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) tbl_m[i] = 64'h0;
    for (int i = 0; i < 4; i++) sh_m[i] = 64'h400F_FFFF_0000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_override();
    t_wrap();
    t_limit();
    t_priv();
    t_null();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule